// File: doc/BRIEF.md
# Write-Cycle Status Read Generator

This block produces the byte a host sees when it reads a byte-wide nonvolatile memory. While the memory's internal programming cycle is running, the array cannot be read. A read then returns a status byte built from the last byte the host loaded. The most significant bit comes back inverted, so the host can poll until the true value appears. A second bit changes state on every separate read access, so the host can also tell "still busy" from "finished" without knowing the data. Once the cycle ends, reads return the array contents again.

The read bus is registered. It carries a separate drive-enable output, so that the pad level can build the tristate buffer. Chip select, output enable and write enable are active-low and are sampled on the clock. A read access starts on the first cycle in which all three show a read. Any of them can end the access, so pulsing either select counts as a new access. The write timer and the storage array belong to neighbouring blocks. They supply the `busy` level and the array data.

Top module: `eow_status_gen`

## Requirements
- R1: `dout_en` is 1 exactly in the cycle after one in which `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise it is 0, and `dout` is then 0.
- R2: With `busy`=0 during a read, `dout` equals the `rd_data` of the previous cycle.
- R3: With `busy`=1 during a read, `dout[7]` is the inverse of bit 7 of the last byte loaded through `wr_stb`.
- R4: With `busy`=1 during a read, `dout[5:0]` equal bits 5..0 of the last loaded byte, and `rd_data` has no effect.
- R5: With `busy`=1, `dout[6]` takes the opposite value on each new read access compared with the previous access.
- R6: A rising edge of `busy` resets the toggle, so that the first access in every write cycle returns `dout[6]`=1. This holds however late in the cycle that first access comes.
- R7: A read held over several cycles counts as one access. Raising and lowering either `oe_n` or `ce_n` starts a new access.
- R8: Cycles with `we_n`=0 are not driven and do not count as accesses.
- R9: The last byte is captured on any cycle with `wr_stb`=1. A busy period with no new byte loaded, such as a blocked write, still returns status built from the previously loaded byte.
- R10: After `busy` falls, bit 6 stops changing and all bits carry `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal programming cycle in progress |
| wr_stb | input | 1 | One-cycle pulse: a byte was loaded by the host |
| wr_data | input | DATA_W | Byte loaded by the host |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rd_data | input | DATA_W | True array data for the current address |
| dout | output | DATA_W | Registered read bus value |
| dout_en | output | 1 | Registered drive enable for the pad tristate |

## Verification
The assertions assume that `wr_stb` never falls in a cycle that is also a read. They also assume that `busy` moves only between accesses, so every status byte is built from a settled last byte and a settled busy level. The stimulus keeps to this. It loads bytes and moves `busy` only while both selects are high, and it changes `rd_data` freely during busy periods to show that this input is ignored there.

// File: rtl/eow_pkg.sv
package eow_pkg;
  typedef struct packed {
    logic active;
    logic start;
  } rd_evt_t;
endpackage

// File: rtl/eow_read_detect.sv
module eow_read_detect
  import eow_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  output rd_evt_t evt
);
  logic act;
  logic act_q;

  assign act = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= act;
  end

  // a new access is the first cycle of an active read
  assign evt.active = act;
  assign evt.start  = act & ~act_q;
endmodule

// File: rtl/eow_last_byte.sv
module eow_last_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] last
);
  always_ff @(posedge clk) begin
    if (rst)         last <= '0;
    else if (wr_stb) last <= wr_data;
  end
endmodule

// File: rtl/eow_toggle.sv
module eow_toggle (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic rd_start,
  output logic tog_next
);
  logic busy_q;
  logic tog_q;
  logic base;

  // new write cycle clears; each access inside busy flips
  assign base     = (busy & ~busy_q) ? 1'b0 : tog_q;
  assign tog_next = base ^ (busy & rd_start);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
    end else begin
      busy_q <= busy;
      tog_q  <= tog_next;
    end
  end
endmodule

// File: rtl/eow_out_mux.sv
module eow_out_mux #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              rd_active,
  input  logic              tog,
  input  logic [DATA_W-1:0] last,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [DATA_W-1:0] status;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == POLL_BIT) begin : g_poll
      assign status[i] = ~last[i];
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign status[i] = tog;
    end else begin : g_pass
      assign status[i] = last[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= rd_active;
      if (!rd_active) dout <= '0;
      else if (busy)  dout <= status;
      else            dout <= rd_data;
    end
  end
endmodule

// File: rtl/eow_status_gen.sv
module eow_status_gen
  import eow_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  rd_evt_t           evt;
  logic [DATA_W-1:0] last;
  logic              tog;

  eow_read_detect u_det (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .evt(evt)
  );

  eow_last_byte #(.DATA_W(DATA_W)) u_last (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data), .last(last)
  );

  eow_toggle u_tog (
    .clk(clk), .rst(rst), .busy(busy), .rd_start(evt.start), .tog_next(tog)
  );

  eow_out_mux #(.DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)) u_mux (
    .clk(clk), .rst(rst), .busy(busy), .rd_active(evt.active), .tog(tog),
    .last(last), .rd_data(rd_data), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: rtl/eow_status_chk.sv
module eow_status_chk #(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic              rd_now;
  logic [DATA_W-1:0] seen_last;

  assign rd_now = ~ce_n & ~oe_n & we_n;

  always_ff @(posedge clk) begin
    if (rst)         seen_last <= '0;
    else if (wr_stb) seen_last <= wr_data;
  end

  // R1
  en_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_now |=> dout_en);

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_now |=> (!dout_en && dout == '0));

  // R8
  write_not_driven_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dout_en);

  // R3
  poll_bit_inverted_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_now && !wr_stb) |=> (dout[POLL_BIT] == ~$past(seen_last[POLL_BIT])));

  // R7
  held_read_toggle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_now && $past(rd_now) && busy && $past(busy)) |=> $stable(dout[TOGGLE_BIT]));

  // R10
  true_data_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && rd_now) |=> (dout == $past(rd_data)));
endmodule

bind eow_status_gen eow_status_chk #(
  .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .wr_stb(wr_stb), .wr_data(wr_data),
  .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rd_data(rd_data),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/eow_status_gen_tb.sv
module eow_status_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       busy = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ce_n = 1'b1;
  logic       oe_n = 1'b1;
  logic       we_n = 1'b1;
  logic [7:0] rd_data = '0;
  logic [7:0] dout;
  logic       dout_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  eow_status_gen u_dut (
    .clk(clk), .rst(rst), .busy(busy), .wr_stb(wr_stb), .wr_data(wr_data),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rd_data(rd_data),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic load_byte(logic [7:0] b);
    wr_data = b; wr_stb = 1'b1; tick(); wr_stb = 1'b0;
  endtask

  // start an access (both selects low), check the returned byte
  task automatic read_byte(string tag, logic [7:0] exp);
    ce_n = 1'b0; oe_n = 1'b0; tick();
    chk({tag, " en"}, {7'd0, dout_en}, 8'h01);
    chk(tag, dout, exp);
  endtask

  task automatic release_all(string tag);
    ce_n = 1'b1; oe_n = 1'b1; tick();
    chk(tag, {dout_en, dout[6:0]}, 8'h00);
    chk({tag, " hi"}, {7'd0, dout[7]}, 8'h00);
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 reset en", {7'd0, dout_en}, 8'h00);
    chk("R1 reset dout", dout, 8'h00);
    rst = 1'b0; tick();
  endtask

  task automatic t_idle_read();
    rd_data = 8'hA5;
    read_byte("R2 idle read", 8'hA5);
    rd_data = 8'h5A; tick();
    chk("R2 follows rd_data", dout, 8'h5A);
    release_all("R1 released");
  endtask

  task automatic t_write_enable_low();
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; tick();
    chk("R8 we low en", {7'd0, dout_en}, 8'h00);
    chk("R8 we low dout", dout, 8'h00);
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tick();
  endtask

  task automatic t_poll_toggle();
    load_byte(8'h3C);
    busy = 1'b1; rd_data = 8'hFF; tick();
    read_byte("R3 R4 R6 first poll", 8'hFC);
    rd_data = 8'h00; tick();
    chk("R7 held read", dout, 8'hFC);
    oe_n = 1'b1; tick();
    chk("R1 oe high", {7'd0, dout_en}, 8'h00);
    oe_n = 1'b0; tick();
    chk("R5 second poll via oe", dout, 8'hBC);
    ce_n = 1'b1; tick();
    chk("R1 ce high", {7'd0, dout_en}, 8'h00);
    ce_n = 1'b0; tick();
    chk("R7 third poll via ce", dout, 8'hFC);
    release_all("R1 release poll");
    // R8: a write-enable low cycle in busy does not advance the toggle
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0; tick();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; tick();
    load_byte(8'h81);
    read_byte("R3 R8 new byte poll", 8'h01);
    release_all("R1 release");
  endtask

  task automatic t_done();
    busy = 1'b0; rd_data = 8'h77; tick();
    read_byte("R10 true data", 8'h77);
    release_all("R1 release");
    read_byte("R10 no toggle", 8'h77);
    release_all("R1 release");
  endtask

  task automatic t_new_cycle();
    busy = 1'b1; rd_data = 8'h00; tick();
    read_byte("R6 first of cycle", 8'h41);
    release_all("R1 release");
    read_byte("R5 second", 8'h01);
    release_all("R1 release");
    read_byte("R5 third", 8'h41);
    release_all("R1 release");
    busy = 1'b0; tick();
    busy = 1'b1; repeat (20) tick();
    read_byte("R6 R9 late poll blocked write", 8'h41);
    release_all("R1 release");
    busy = 1'b0; tick();
  endtask

  initial begin
    t_reset();
    t_idle_read();
    t_write_enable_low();
    t_poll_toggle();
    t_done();
    t_new_cycle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule